// File: doc/BRIEF.md
# Pulse Width Capture Timer

This block times a digital input by counting ticks of a prescaled count clock between two chosen edges of that input. It can time a high phase, a low phase, a rising-to-rising period or a falling-to-falling period. In the two period modes an optional input divider lets one count run across 4, 16, 64 or 256 input periods, so the per-period value is the count divided by that rate. The input is synchronised inside the block before any edge is acted on.

Each finished count is copied into a result register that a host reads over a plain register port with read and write strobes. The block has no streaming data port. The result register is the only data path out, and it cannot apply back-pressure: the timer never waits for the host. If the host falls behind, a newer result replaces the unread one and an error flag records the overrun. Reading the result clears that flag. A done flag, which can raise an interrupt line, reports each completed count. In single-shot mode the timer stops after one result. In continuous mode it keeps measuring, and the result register keeps showing the last finished value until the next one completes.

Register map (`addr`): 0 = control, 1 = status, 2 = result (read only), 3 = divider rate select. Control bits: [0] run, [1] continuous, [3:2] count clock select, [5:4] measurement type (00 high width, 01 low width, 10 rising-to-rising, 11 falling-to-falling), [6] interrupt enable, [7] divider enable. Status bits: [0] done, [1] overrun error, [2] counter saturated, [3] busy. Writing a 1 to status bit 0 clears done, and writing a 1 to status bit 2 clears saturated. Divider select bits [1:0]: 00 = 4, 01 = 16, 10 = 64, 11 = 256 periods.

Top module: `pulse_capture_timer`

## Requirements
- R1: After reset, status reads 0, result reads 0 and `irq` is low.
- R2: In a width mode the result is floor(W/P). W is the pulse length in clock cycles. P is 4, 16 or 32 for count clock select 00, 01 or 10 (11 also gives 32), and the prescaler restarts at the start edge.
- R3: In a period mode the result is floor(T/P) for an input period of T cycles. In continuous mode the closing edge of one period also opens the next, so back-to-back periods give back-to-back results.
- R4: With the divider enabled in a period mode, one result spans N periods and equals floor(N*T/P), where N comes from the divider select. The divider has no effect in the width modes.
- R5: In single-shot mode, once a result is stored, run and busy clear and later input edges produce no result until software sets run again.
- R6: The result register holds the last finished value while a new count runs. The live counter is never visible on the read port.
- R7: A result that completes while the previous one is still unread replaces it and sets the overrun error flag.
- R8: Reading the result register clears the error flag. If the read falls in the same cycle as a new result latch, the flag is set instead.
- R9: The counter saturates at its all-ones value (CNT_W bits) and does not wrap. A tick that arrives while the counter is saturated sets the saturated status bit.
- R10: Each stored result sets done. `irq` equals done AND interrupt enable, and writing 1 to status bit 0 clears done.
- R11: An input pulse of 2 clock cycles is always detected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Machine clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pin_in | input | 1 | Asynchronous input being measured |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (enables read side effects) |
| addr | input | 2 | Register select |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data, combinational from `addr` |
| irq | output | 1 | Measurement-done interrupt request |

## Verification
An input edge driven on a falling clock edge reaches the edge detector after two synchroniser flops. The result latches on the third rising edge after the change, done and `irq` rise with it, and reading status or result afterwards is a combinational peek. The bench drives the stimulus on falling edges and pushes the expected count into a scoreboard queue before the closing edge. A monitor waits for `irq`, reads the result and pops the queue to compare. For the same-cycle read-and-latch case, the read strobe is placed exactly two falling edges after the closing input change, so that it covers the latching edge.

// File: rtl/pct_pkg.sv
package pct_pkg;
  typedef enum logic [1:0] {
    M_HIGH = 2'b00,
    M_LOW  = 2'b01,
    M_RISE = 2'b10,
    M_FALL = 2'b11
  } meas_mode_t;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'b00,
    ST_ARMED = 2'b01,
    ST_COUNT = 2'b10
  } meas_state_t;

  localparam logic [1:0] A_CTRL = 2'd0;
  localparam logic [1:0] A_STAT = 2'd1;
  localparam logic [1:0] A_RES  = 2'd2;
  localparam logic [1:0] A_DIV  = 2'd3;

  localparam int PRESC_W = 6;
  localparam int EDGE_W  = 9;

  function automatic logic [PRESC_W-1:0] presc_len(input logic [1:0] sel);
    case (sel)
      2'b00:   return PRESC_W'(4);
      2'b01:   return PRESC_W'(16);
      default: return PRESC_W'(32);
    endcase
  endfunction

  function automatic logic [EDGE_W-1:0] div_rate(input logic [1:0] code);
    case (code)
      2'b00:   return EDGE_W'(4);
      2'b01:   return EDGE_W'(16);
      2'b10:   return EDGE_W'(64);
      default: return EDGE_W'(256);
    endcase
  endfunction
endpackage

// File: rtl/pct_sync_edge.sv
module pct_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  output logic rise,
  output logic fall
);
  logic [STAGES-1:0] chain_q;
  logic              prev_q;
  logic              synced;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) chain_q <= '0;
        else        chain_q <= pin;
    end else begin : g_many
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) chain_q <= '0;
        else        chain_q <= {chain_q[STAGES-2:0], pin};
    end
  endgenerate

  assign synced = chain_q[STAGES-1];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= synced;

  assign rise = synced & ~prev_q;
  assign fall = ~synced & prev_q;
endmodule

// File: rtl/pct_prescaler.sv
module pct_prescaler
  import pct_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clear,
  input  logic               enable,
  input  logic [PRESC_W-1:0] len,
  output logic               tick
);
  logic [PRESC_W-1:0] cnt_q;
  logic               wrap;

  assign wrap = (cnt_q == len - PRESC_W'(1));
  assign tick = enable & wrap;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)      cnt_q <= '0;
    else if (clear)  cnt_q <= '0;
    else if (enable) cnt_q <= wrap ? '0 : cnt_q + PRESC_W'(1);
endmodule

// File: rtl/pct_measure.sv
module pct_measure
  import pct_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             cont,
  input  meas_mode_t       mode,
  input  logic             div_en,
  input  logic [1:0]       div_code,
  input  logic             rise,
  input  logic             fall,
  input  logic             tick,
  output logic             presc_clear,
  output logic             presc_en,
  output logic             latch,
  output logic [CNT_W-1:0] res_val,
  output logic             sat_evt,
  output logic             busy
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  meas_state_t       state_q;
  logic [CNT_W-1:0]  cnt_q, cnt_nxt;
  logic [EDGE_W-1:0] ecnt_q, need;
  logic              start_edge, end_edge, period, finish, counting;

  always_comb begin
    case (mode)
      M_HIGH:  begin start_edge = rise; end_edge = fall; end
      M_LOW:   begin start_edge = fall; end_edge = rise; end
      M_RISE:  begin start_edge = rise; end_edge = rise; end
      default: begin start_edge = fall; end_edge = fall; end
    endcase
  end

  assign period   = mode[1];
  assign need     = (period && div_en) ? div_rate(div_code) : EDGE_W'(1);
  assign counting = (state_q == ST_COUNT);
  assign finish   = counting && run && end_edge && (ecnt_q == need - EDGE_W'(1));
  assign cnt_nxt  = (tick && cnt_q != CNT_MAX) ? cnt_q + CNT_W'(1) : cnt_q;

  assign latch       = finish;
  assign res_val     = cnt_nxt;
  assign sat_evt     = counting && tick && (cnt_q == CNT_MAX);
  assign presc_en    = counting;
  assign presc_clear = !counting || finish;
  assign busy        = (state_q != ST_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      ecnt_q  <= '0;
    end else if (!run) begin
      state_q <= ST_IDLE;
    end else begin
      case (state_q)
        ST_IDLE: state_q <= ST_ARMED;
        ST_ARMED:
          if (start_edge) begin
            state_q <= ST_COUNT;
            cnt_q   <= '0;
            ecnt_q  <= '0;
          end
        ST_COUNT:
          if (finish) begin
            if (!cont)       state_q <= ST_IDLE;
            else if (period) begin
              cnt_q  <= '0;
              ecnt_q <= '0;
            end else         state_q <= ST_ARMED;
          end else begin
            cnt_q <= cnt_nxt;
            if (end_edge) ecnt_q <= ecnt_q + EDGE_W'(1);
          end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // R9
  sat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (counting && run && cnt_q == CNT_MAX && !end_edge) |=> (cnt_q == CNT_MAX));

  // R5
  single_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (latch && !cont) |=> (state_q == ST_IDLE));
endmodule

// File: rtl/pct_result.sv
module pct_result #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             latch,
  input  logic [CNT_W-1:0] val,
  input  logic             rd_res,
  input  logic             clr_done,
  input  logic             clr_sat,
  input  logic             sat_evt,
  output logic [CNT_W-1:0] result,
  output logic             err,
  output logic             done,
  output logic             sat
);
  logic full_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      result <= '0;
      full_q <= 1'b0;
      err    <= 1'b0;
    end else if (latch) begin
      result <= val;
      full_q <= 1'b1;
      if (full_q) err <= 1'b1;
    end else if (rd_res) begin
      full_q <= 1'b0;
      err    <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        done <= 1'b0;
    else if (latch)    done <= 1'b1;
    else if (clr_done) done <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       sat <= 1'b0;
    else if (sat_evt) sat <= 1'b1;
    else if (clr_sat) sat <= 1'b0;
  end

  // R7
  overrun_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (latch && full_q) |=> err);

  // R8
  rd_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_res && !latch) |=> !err);

  // R6
  hold_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !latch |=> $stable(result));
endmodule

// File: rtl/pulse_capture_timer.sv
module pulse_capture_timer
  import pct_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int DATA_W      = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pin_in,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [1:0]        addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              irq
);
  logic       run_q, cont_q, irq_en_q, div_en_q;
  logic [1:0] sel_q, div_code_q;
  meas_mode_t mode_q;

  logic wr_ctrl, wr_stat, wr_div, rd_res;
  logic rise, fall, tick, presc_clear, presc_en, latch, sat_evt, busy;
  logic err, done, sat;
  logic [CNT_W-1:0] res_val, result;
  logic unused_wbits;

  assign wr_ctrl = wr_en && (addr == A_CTRL);
  assign wr_stat = wr_en && (addr == A_STAT);
  assign wr_div  = wr_en && (addr == A_DIV);
  assign rd_res  = rd_en && (addr == A_RES);
  assign unused_wbits = ^wdata[DATA_W-1:8];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q    <= 1'b0;
      cont_q   <= 1'b0;
      sel_q    <= 2'b00;
      mode_q   <= M_HIGH;
      irq_en_q <= 1'b0;
      div_en_q <= 1'b0;
    end else if (wr_ctrl) begin
      run_q    <= wdata[0];
      cont_q   <= wdata[1];
      sel_q    <= wdata[3:2];
      mode_q   <= meas_mode_t'(wdata[5:4]);
      irq_en_q <= wdata[6];
      div_en_q <= wdata[7];
    end else if (latch && !cont_q) begin
      run_q <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)      div_code_q <= 2'b00;
    else if (wr_div) div_code_q <= wdata[1:0];

  pct_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .pin(pin_in), .rise(rise), .fall(fall)
  );

  pct_prescaler u_presc (
    .clk(clk), .rst_n(rst_n), .clear(presc_clear), .enable(presc_en),
    .len(presc_len(sel_q)), .tick(tick)
  );

  pct_measure #(.CNT_W(CNT_W)) u_meas (
    .clk(clk), .rst_n(rst_n), .run(run_q), .cont(cont_q), .mode(mode_q),
    .div_en(div_en_q), .div_code(div_code_q), .rise(rise), .fall(fall),
    .tick(tick), .presc_clear(presc_clear), .presc_en(presc_en),
    .latch(latch), .res_val(res_val), .sat_evt(sat_evt), .busy(busy)
  );

  pct_result #(.CNT_W(CNT_W)) u_res (
    .clk(clk), .rst_n(rst_n), .latch(latch), .val(res_val), .rd_res(rd_res),
    .clr_done(wr_stat && wdata[0]), .clr_sat(wr_stat && wdata[2]),
    .sat_evt(sat_evt), .result(result), .err(err), .done(done), .sat(sat)
  );

  always_comb begin
    case (addr)
      A_CTRL:  rdata = DATA_W'({div_en_q, irq_en_q, mode_q, sel_q, cont_q, run_q});
      A_STAT:  rdata = DATA_W'({busy, sat, err, done});
      A_RES:   rdata = DATA_W'(result);
      default: rdata = DATA_W'(div_code_q);
    endcase
  end

  assign irq = done & irq_en_q;

  // R10
  irq_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (latch && irq_en_q && !wr_ctrl) |=> irq);
endmodule

// File: tb/pulse_capture_timer_bench.sv
module pulse_capture_timer_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        pin_in = 1'b0;
  logic        wr_en = 1'b0;
  logic        rd_en = 1'b0;
  logic [1:0]  addr = 2'd0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic        irq;

  int checks = 0;
  int errors = 0;
  int    exp_q[$];
  string tag_q[$];
  bit    mon_on = 1'b0;
  bit    mon_busy = 1'b0;

  always #2 clk = ~clk;

  pulse_capture_timer #(.CNT_W(10)) u_pulse_capture_timer (
    .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic bus_read(input logic [1:0] a, output int d);
    @(negedge clk);
    addr = a; rd_en = 1'b1;
    #1 d = int'(rdata);
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  function automatic logic [15:0] ctrl_word(input bit run, input bit cont,
      input int sel, input int mode, input bit ien, input bit den);
    return 16'(run) | (16'(cont) << 1) | (16'(sel) << 2) | (16'(mode) << 4)
         | (16'(ien) << 6) | (16'(den) << 7);
  endfunction

  task automatic pulse_high(input int w, input int gap);
    @(negedge clk); pin_in = 1'b1;
    repeat (w) @(negedge clk);
    pin_in = 1'b0;
    repeat (gap) @(negedge clk);
  endtask

  task automatic pulse_low(input int w, input int gap);
    @(negedge clk); pin_in = 1'b0;
    repeat (w) @(negedge clk);
    pin_in = 1'b1;
    repeat (gap) @(negedge clk);
  endtask

  task automatic expect_val(input int v, input string t);
    exp_q.push_back(v);
    tag_q.push_back(t);
  endtask

  task automatic drain;
    do @(negedge clk); while (exp_q.size() != 0 || mon_busy);
    repeat (4) @(negedge clk);
  endtask

  // monitor: pop and compare each completed result
  initial begin
    int v;
    forever begin
      @(negedge clk);
      if (mon_on && irq) begin
        mon_busy = 1'b1;
        bus_read(2'd2, v);
        if (exp_q.size() == 0) chk("R10 unexpected result", v, -1);
        else begin
          string t;
          int e;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          chk(t, v, e);
        end
        bus_write(2'd1, 16'h0001);
        mon_busy = 1'b0;
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int v;
    int periods[3] = '{96, 160, 64};
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    bus_read(2'd1, v); chk("R1 status", v, 0);
    bus_read(2'd2, v); chk("R1 result", v, 0);
    chk("R1 irq", int'(irq), 0);

    mon_on = 1'b1;
    // R2 high width, P=4
    bus_write(2'd0, ctrl_word(1, 0, 0, 0, 1, 0)); repeat (3) @(negedge clk);
    expect_val(10, "R2 high 43/4"); pulse_high(43, 10); drain();
    // R11 minimal pulse
    bus_write(2'd0, ctrl_word(1, 0, 0, 0, 1, 0)); repeat (3) @(negedge clk);
    expect_val(0, "R11 two-cycle pulse"); pulse_high(2, 10); drain();
    // R2 low width, P=16
    pin_in = 1'b1; repeat (5) @(negedge clk);
    bus_write(2'd0, ctrl_word(1, 0, 1, 1, 1, 0)); repeat (3) @(negedge clk);
    expect_val(6, "R2 low 100/16"); pulse_low(100, 10); drain();
    pin_in = 1'b0; repeat (5) @(negedge clk);
    // R4 divider ignored in width mode, P=16
    bus_write(2'd3, 16'h0003);
    bus_write(2'd0, ctrl_word(1, 0, 1, 0, 1, 1)); repeat (3) @(negedge clk);
    expect_val(10, "R4 divider ignored in width mode"); pulse_high(160, 10); drain();

    // R3 continuous rising-to-rising, P=32
    bus_write(2'd0, ctrl_word(1, 1, 2, 2, 1, 0)); repeat (3) @(negedge clk);
    @(negedge clk); pin_in = 1'b1;
    foreach (periods[i]) begin
      repeat (periods[i] / 2) @(negedge clk);
      pin_in = 1'b0;
      repeat (periods[i] - periods[i] / 2) @(negedge clk);
      expect_val(periods[i] / 32, "R3 continuous period");
      pin_in = 1'b1;
    end
    drain();
    bus_write(2'd0, 16'h0000);
    pin_in = 1'b0; repeat (5) @(negedge clk);

    // R4 falling-to-falling with divider N=4, P=4, single-shot
    bus_write(2'd3, 16'h0000);
    bus_write(2'd0, ctrl_word(1, 0, 0, 3, 1, 1)); repeat (3) @(negedge clk);
    expect_val(20, "R4 divide-by-4 span");
    pin_in = 1'b1; repeat (10) @(negedge clk);
    pin_in = 1'b0; repeat (10) @(negedge clk);
    for (int k = 0; k < 5; k++) begin
      pin_in = 1'b1; repeat (10) @(negedge clk);
      pin_in = 1'b0; repeat (10) @(negedge clk);
    end
    drain();
    // R5 stopped after single shot
    pulse_high(40, 20);
    bus_read(2'd1, v); chk("R5 status after single shot", v, 0);
    bus_read(2'd0, v); chk("R5 run bit cleared", v & 1, 0);

    // R9 saturation, P=4, CNT_W=10
    bus_write(2'd0, ctrl_word(1, 0, 0, 0, 1, 0)); repeat (3) @(negedge clk);
    expect_val(1023, "R9 saturated result"); pulse_high(5000, 10); drain();
    bus_read(2'd1, v); chk("R9 saturated flag", v, 4);
    bus_write(2'd1, 16'h0004);
    bus_read(2'd1, v); chk("R9 saturated flag cleared", v, 0);
    mon_on = 1'b0;

    // R10 done and irq, write-one-to-clear
    bus_write(2'd0, ctrl_word(1, 0, 0, 0, 1, 0)); repeat (3) @(negedge clk);
    pulse_high(40, 10);
    chk("R10 irq raised", int'(irq), 1);
    bus_read(2'd2, v); chk("R10 result", v, 10);
    bus_write(2'd1, 16'h0001);
    chk("R10 irq cleared", int'(irq), 0);

    // R7 overrun in continuous high width, P=4, no interrupt
    bus_write(2'd0, ctrl_word(1, 1, 0, 0, 0, 0)); repeat (3) @(negedge clk);
    pulse_high(40, 20);
    pulse_high(80, 10);
    bus_read(2'd1, v); chk("R7 error flag", (v >> 1) & 1, 1);
    bus_read(2'd2, v); chk("R7 newest result kept", v, 20);
    bus_read(2'd1, v); chk("R8 error cleared by read", (v >> 1) & 1, 0);

    // R8 read coinciding with latch
    pulse_high(60, 10);
    @(negedge clk); pin_in = 1'b1;
    repeat (100) @(negedge clk);
    pin_in = 1'b0;
    @(negedge clk); @(negedge clk);
    addr = 2'd2; rd_en = 1'b1;
    #1 v = int'(rdata);
    @(negedge clk); rd_en = 1'b0;
    chk("R6 previous result during latch", v, 15);
    bus_read(2'd1, v); chk("R8 same-cycle latch sets error", (v >> 1) & 1, 1);
    bus_read(2'd2, v); chk("R8 new result", v, 25);
    bus_write(2'd0, 16'h0000);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule